// File: doc/BRIEF.md
# Decode-Stall Hazard Controller

This block decides, every cycle, whether the instruction sitting in the decode stage of a five-stage integer pipeline may move on. The pipeline has no operand forwarding. A source register that is still being produced by an older instruction can only be read once that result has reached the register file. The register file is assumed to pass a value being written back straight to a same-cycle read in decode, so an older writer that has reached the writeback stage no longer blocks.

The controller keeps its own short record of the destination registers that are in flight. Each cycle it pushes the destination of the instruction that leaves decode, or an empty slot when a bubble is inserted. It compares the decode-stage source fields against that record. On a match it freezes the program counter and the IF/ID register and sends a bubble into ID/EX. When a taken branch or jump resolves in execute, it squashes IF/ID and ID/EX and selects the target for the program counter. This redirect overrides any stall decided in the same cycle. A parameter selects whether the writeback pass-through exists. Without it, the tracked window grows by one stage.

The decision is a three-way choice between `HZ_FLOW`, `HZ_HOLD` and `HZ_SQUASH`, made fresh every cycle. `HZ_SQUASH` wins over `HZ_HOLD`, and `HZ_HOLD` wins over `HZ_FLOW`. The only stored state is the in-flight record.

Top module: `hz_stall_unit`

## Requirements
- R1: Register x0 (source field value 0) never causes a stall, whatever the in-flight writers name as destination.
- R2: A dependence counts only when the decode slot is valid (`id_valid`=1), the source is marked as read (`id_rs1_rd`/`id_rs2_rd`=1) and the older instruction had its write enable (`id_rd_we`=1) when it left decode.
- R3: With writeback pass-through (`BYPASS_WB`=1), a dependence on the instruction that left decode one cycle earlier stalls exactly two cycles. A dependence on the one two cycles earlier stalls one cycle, and an older one causes no stall. Loads and ALU operations are treated alike.
- R4: During a stall, `pc_hold`, `ifid_hold` and `idex_bubble` are all 1, and `ifid_flush` and `pc_load_target` are 0.
- R5: When `ex_redirect`=1, `ifid_flush`, `idex_bubble` and `pc_load_target` are 1 and `pc_hold` and `ifid_hold` are 0, even if a stall would otherwise apply.
- R6: An instruction replaced by a bubble, either squashed by a redirect or held by a stall, is not recorded as an in-flight writer in that cycle.
- R7: Reset empties the in-flight record, so a reader presented in the first cycle after reset does not stall.
- R8: Without pass-through (`BYPASS_WB`=0), the stall lengths for distances 1, 2 and 3 are 3, 2 and 1 cycles, and greater distances cause no stall.
- R9: A pipeline steered by the controller, running dependent addi chains and a load followed by a use, ends with the same register values as a sequential execution and spends exactly the expected number of stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_rs1 | input | REG_AW | First source register of the decode instruction |
| id_rs1_rd | input | 1 | First source is read by this format |
| id_rs2 | input | REG_AW | Second source register |
| id_rs2_rd | input | 1 | Second source is read by this format |
| id_rd | input | REG_AW | Destination register of the decode instruction |
| id_rd_we | input | 1 | Decode instruction writes its destination |
| ex_redirect | input | 1 | Taken branch or jump resolved in execute |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the IF/ID register unchanged |
| ifid_flush | output | 1 | Invalidate the IF/ID register |
| idex_bubble | output | 1 | Load a bubble (valid and write enables cleared) into ID/EX |
| pc_load_target | output | 1 | Load the program counter from the resolved target |

## Verification
A corrupted slot in the in-flight record shows up at the ports within one to three cycles of the writer leaving decode. It appears either as an extra `pc_hold` cycle against an unrelated reader or as a missing one against a true dependence. A slot that keeps an instruction squashed by a redirect shows as a spurious stall on the very next reader of that register. The bench therefore measures stall lengths over a sweep of writer distance, register pairs, read flags and write enables, for both record depths. It also runs a small pipeline and compares the final register values.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        HZ_FLOW   = 2'd0,
        HZ_HOLD   = 2'd1,
        HZ_SQUASH = 2'd2
    } hz_act_e;
endpackage

// File: rtl/hz_inflight.sv
module hz_inflight #(
    parameter int AW    = 5,
    parameter int DEPTH = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push_live,
    input  logic [AW-1:0]             push_rd,
    output logic [DEPTH-1:0]          live,
    output logic [DEPTH-1:0][AW-1:0]  rd
);
    // slot 0 = execute stage, higher slots = later stages
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live <= '0;
            rd   <= '0;
        end else begin
            for (int k = DEPTH - 1; k > 0; k--) begin
                live[k] <= live[k-1];
                rd[k]   <= rd[k-1];
            end
            live[0] <= push_live;
            rd[0]   <= push_rd;
        end
    end
endmodule

// File: rtl/hz_match.sv
module hz_match #(
    parameter int AW    = 5,
    parameter int DEPTH = 2
) (
    input  logic                      valid,
    input  logic [AW-1:0]             src1,
    input  logic                      use1,
    input  logic [AW-1:0]             src2,
    input  logic                      use2,
    input  logic [DEPTH-1:0]          live,
    input  logic [DEPTH-1:0][AW-1:0]  rd,
    output logic                      dep
);
    logic             s1_on;
    logic             s2_on;
    logic [DEPTH-1:0] hit_vec;

    assign s1_on = use1 && (src1 != '0);
    assign s2_on = use2 && (src2 != '0);

    for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
        assign hit_vec[k] = live[k] &&
                            ((s1_on && (src1 == rd[k])) || (s2_on && (src2 == rd[k])));
    end

    assign dep = valid && (|hit_vec);
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
(
    input  logic    redirect,
    input  logic    dep,
    output hz_act_e act,
    output logic    pc_hold,
    output logic    ifid_hold,
    output logic    ifid_flush,
    output logic    idex_bubble,
    output logic    pc_load_target
);
    always_comb begin
        if (redirect)  act = HZ_SQUASH;
        else if (dep)  act = HZ_HOLD;
        else           act = HZ_FLOW;
    end

    always_comb begin
        pc_hold        = 1'b0;
        ifid_hold      = 1'b0;
        ifid_flush     = 1'b0;
        idex_bubble    = 1'b0;
        pc_load_target = 1'b0;
        unique case (act)
            HZ_FLOW: begin
            end
            HZ_HOLD: begin
                pc_hold     = 1'b1;
                ifid_hold   = 1'b1;
                idex_bubble = 1'b1;
            end
            HZ_SQUASH: begin
                ifid_flush     = 1'b1;
                idex_bubble    = 1'b1;
                pc_load_target = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
    import hz_pkg::*;
#(
    parameter int REG_AW    = 5,
    parameter bit BYPASS_WB = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic              id_rs1_rd,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_rs2_rd,
    input  logic [REG_AW-1:0] id_rd,
    input  logic              id_rd_we,
    input  logic              ex_redirect,
    output logic              pc_hold,
    output logic              ifid_hold,
    output logic              ifid_flush,
    output logic              idex_bubble,
    output logic              pc_load_target
);
    localparam int DEPTH = BYPASS_WB ? 2 : 3;

    logic [DEPTH-1:0]             slot_live;
    logic [DEPTH-1:0][REG_AW-1:0] slot_rd;
    logic                         dep;
    logic                         push_live;
    hz_act_e                      act;

    assign push_live = id_valid && id_rd_we && (id_rd != '0) && (act == HZ_FLOW);

    hz_inflight #(.AW(REG_AW), .DEPTH(DEPTH)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_live (push_live),
        .push_rd   (id_rd),
        .live      (slot_live),
        .rd        (slot_rd)
    );

    hz_match #(.AW(REG_AW), .DEPTH(DEPTH)) u_match (
        .valid (id_valid),
        .src1  (id_rs1),
        .use1  (id_rs1_rd),
        .src2  (id_rs2),
        .use2  (id_rs2_rd),
        .live  (slot_live),
        .rd    (slot_rd),
        .dep   (dep)
    );

    hz_ctrl u_ctrl (
        .redirect       (ex_redirect),
        .dep            (dep),
        .act            (act),
        .pc_hold        (pc_hold),
        .ifid_hold      (ifid_hold),
        .ifid_flush     (ifid_flush),
        .idex_bubble    (idex_bubble),
        .pc_load_target (pc_load_target)
    );
endmodule

// File: rtl/hz_stall_unit_chk.sv
module hz_stall_unit_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          id_valid,
    input logic [AW-1:0] id_rs1,
    input logic          id_rs1_rd,
    input logic [AW-1:0] id_rs2,
    input logic          id_rs2_rd,
    input logic [AW-1:0] id_rd,
    input logic          id_rd_we,
    input logic          ex_redirect,
    input logic          pc_hold,
    input logic          ifid_hold,
    input logic          ifid_flush,
    input logic          idex_bubble,
    input logic          pc_load_target
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_NO_X0_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && (!id_rs1_rd || id_rs1 == '0) && (!id_rs2_rd || id_rs2 == '0)) |-> !pc_hold); // R1

    AST_EMPTY_SLOT_FLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> !pc_hold); // R2

    AST_NEAR_WRITER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(id_valid && id_rd_we && (id_rd != '0) && !idex_bubble) &&
         id_valid && id_rs1_rd && (id_rs1 == $past(id_rd)) && !ex_redirect) |-> pc_hold); // R3

    AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (ifid_hold && idex_bubble && !ifid_flush && !pc_load_target)); // R4

    AST_REDIRECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ex_redirect |-> (pc_load_target && ifid_flush && idex_bubble && !pc_hold && !ifid_hold)); // R5
endmodule

bind hz_stall_unit hz_stall_unit_chk #(.AW(REG_AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .id_valid       (id_valid),
    .id_rs1         (id_rs1),
    .id_rs1_rd      (id_rs1_rd),
    .id_rs2         (id_rs2),
    .id_rs2_rd      (id_rs2_rd),
    .id_rd          (id_rd),
    .id_rd_we       (id_rd_we),
    .ex_redirect    (ex_redirect),
    .pc_hold        (pc_hold),
    .ifid_hold      (ifid_hold),
    .ifid_flush     (ifid_flush),
    .idex_bubble    (idex_bubble),
    .pc_load_target (pc_load_target)
);

// File: tb/hz_stall_unit_tb.sv
`timescale 1ns/1ps
module hz_stall_unit_tb;
    localparam int AW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic id_valid = 1'b0, id_rs1_rd = 1'b0, id_rs2_rd = 1'b0, id_rd_we = 1'b0, ex_redirect = 1'b0;
    logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, id_rd = '0;
    logic hold_a, ifh_a, flush_a, bub_a, tgt_a;
    logic hold_b, ifh_b, flush_b, bub_b, tgt_b;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    hz_stall_unit #(.REG_AW(AW), .BYPASS_WB(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_rs1(id_rs1), .id_rs1_rd(id_rs1_rd),
        .id_rs2(id_rs2), .id_rs2_rd(id_rs2_rd), .id_rd(id_rd), .id_rd_we(id_rd_we),
        .ex_redirect(ex_redirect), .pc_hold(hold_a), .ifid_hold(ifh_a), .ifid_flush(flush_a),
        .idex_bubble(bub_a), .pc_load_target(tgt_a));

    hz_stall_unit #(.REG_AW(AW), .BYPASS_WB(1'b0)) u_dut_nb (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_rs1(id_rs1), .id_rs1_rd(id_rs1_rd),
        .id_rs2(id_rs2), .id_rs2_rd(id_rs2_rd), .id_rd(id_rd), .id_rd_we(id_rd_we),
        .ex_redirect(ex_redirect), .pc_hold(hold_b), .ifid_hold(ifh_b), .ifid_flush(flush_b),
        .idex_bubble(bub_b), .pc_load_target(tgt_b));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drv(input bit v, input int r1, input bit u1, input int r2, input bit u2,
                       input int rd, input bit we, input bit rdir);
        id_valid = v; id_rs1 = r1[AW-1:0]; id_rs1_rd = u1;
        id_rs2 = r2[AW-1:0]; id_rs2_rd = u2;
        id_rd = rd[AW-1:0]; id_rd_we = we; ex_redirect = rdir;
    endtask

    task automatic cyc(input bit v, input int r1, input bit u1, input int r2, input bit u2,
                       input int rd, input bit we, input bit rdir);
        drv(v, r1, u1, r2, u2, rd, we, rdir);
        @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic flush3();
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // consumer already driven; count stall cycles of both instances
    task automatic measure(output int na, output int nb, output bit r4ok);
        na = 0; nb = 0; r4ok = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (hold_a) begin
                na++;
                if (!(ifh_a && bub_a && !flush_a && !tgt_a)) r4ok = 1'b0;
            end
            if (hold_b) nb++;
            if (!hold_a && !hold_b) break;
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
    endtask

    // pipeline model state
    int p_rd[7], p_rs[7], p_imm[7];
    bit p_ld[7];
    int rf[8], sr[8];

    function automatic int dmem(input int a);
        return (a == 2) ? 32'h55 : 0;
    endfunction

    initial begin
        #150000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int na, nb;
        bit r4ok;

        // R7: reset clears record; writer x1 presented during reset
        drv(1, 0, 0, 0, 0, 1, 1, 0);
        repeat (3) @(posedge clk);
        #1;
        chk(!hold_a && !flush_a && !bub_a && !tgt_a, "R7 outputs in reset", int'(hold_a), 0);
        rst_n = 1'b1;
        drv(1, 1, 1, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk(!hold_a && !hold_b, "R7 reader after reset", int'(hold_a) + int'(hold_b), 0);
        @(posedge clk); #1;

        // R1 R2 R3 R4 R8: sweep writer distance, registers, read flags, write enable
        for (int rd = 0; rd < 4; rd++)
        for (int we = 0; we < 2; we++)
        for (int r1 = 0; r1 < 8; r1++)
        for (int u1 = 0; u1 < 2; u1++)
        for (int k2 = 0; k2 < 4; k2++)
        for (int u2 = 0; u2 < 2; u2++)
        for (int d = 1; d <= 4; d++) begin
            int r2, ea, eb;
            bit hit;
            r2 = (k2 * 3) % 8;
            flush3();
            cyc(1, 0, 0, 0, 0, rd, we[0], 0);
            for (int f = 1; f < d; f++) cyc(1, 0, 0, 0, 0, 0, 0, 0);
            drv(1, r1, u1[0], r2, u2[0], 0, 0, 0);
            hit = (we == 1) && (rd != 0) && ((u1 == 1 && r1 == rd) || (u2 == 1 && r2 == rd));
            ea = (hit && d <= 2) ? 3 - d : 0;
            eb = (hit && d <= 3) ? 4 - d : 0;
            measure(na, nb, r4ok);
            chk(na == ea, "R1/R2/R3 stall length", na, ea);
            chk(nb == eb, "R8 stall length no pass-through", nb, eb);
            chk(r4ok, "R4 hold controls", int'(r4ok), 1);
        end

        // R5 and R6: stall then redirect of a held writer
        flush3();
        cyc(1, 0, 0, 0, 0, 3, 1, 0);
        drv(1, 3, 1, 0, 0, 6, 1, 0);
        @(negedge clk);
        chk(hold_a == 1'b1, "R4 held writer stalls", int'(hold_a), 1);
        @(posedge clk); #1;
        drv(1, 3, 1, 0, 0, 6, 1, 1);
        @(negedge clk);
        chk(!hold_a && !ifh_a && flush_a && bub_a && tgt_a, "R5 redirect over stall",
            int'({hold_a, ifh_a, flush_a, bub_a, tgt_a}), 7);
        chk(!hold_b && flush_b && tgt_b, "R5 redirect no pass-through", int'(hold_b), 0);
        @(posedge clk); #1;
        drv(1, 6, 1, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk(!hold_a && !hold_b, "R6 squashed/held writer not tracked",
            int'(hold_a) + int'(hold_b), 0);
        @(posedge clk); #1;

        // R6: writer squashed in decode by redirect
        flush3();
        drv(1, 0, 0, 0, 0, 5, 1, 1);
        @(negedge clk);
        chk(tgt_a && bub_a && !hold_a, "R5 redirect flow", int'(tgt_a), 1);
        @(posedge clk); #1;
        drv(1, 0, 0, 5, 1, 0, 0, 0);
        @(negedge clk);
        chk(!hold_a && !hold_b, "R6 squashed writer", int'(hold_a) + int'(hold_b), 0);
        @(posedge clk); #1;

        // R2: invalid decode slot does not stall, valid one a cycle later does (MEM writer)
        flush3();
        cyc(1, 0, 0, 0, 0, 2, 1, 0);
        drv(0, 2, 1, 2, 1, 0, 0, 0);
        @(negedge clk);
        chk(!hold_a && !bub_a, "R2 invalid slot", int'(hold_a), 0);
        @(posedge clk); #1;
        drv(1, 2, 1, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk(hold_a == 1'b1, "R3 writer two ahead", int'(hold_a), 1);
        @(posedge clk); #1;
        @(negedge clk);
        chk(hold_a == 1'b0, "R3 one stall only", int'(hold_a), 0);
        @(posedge clk); #1;

        // R3 R8: two writers, both sources dependent
        flush3();
        cyc(1, 0, 0, 0, 0, 1, 1, 0);
        cyc(1, 0, 0, 0, 0, 2, 1, 0);
        drv(1, 1, 1, 2, 1, 0, 0, 0);
        measure(na, nb, r4ok);
        chk(na == 2, "R3 two writers", na, 2);
        chk(nb == 3, "R8 two writers", nb, 3);

        // R9: pipeline program steered by the controller
        p_rd = '{1, 2, 3, 4, 5, 6, 7};
        p_rs = '{0, 1, 2, 0, 4, 3, 5};
        p_imm = '{10, 1, 1, 2, 3, 4, 1};
        p_ld = '{0, 0, 0, 1, 0, 0, 0};
        for (int i = 0; i < 8; i++) begin rf[i] = 0; sr[i] = 0; end
        for (int i = 0; i < 7; i++)
            sr[p_rd[i]] = p_ld[i] ? dmem(sr[p_rs[i]] + p_imm[i]) : sr[p_rs[i]] + p_imm[i];
        rst_n = 1'b0;
        drv(0, 0, 0, 0, 0, 0, 0, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        begin
            int pc, stalls, retired;
            bit fv, dv, ev, wv;
            int fi, di, ei, wi, da, ev_val, wv_val;
            pc = 0; stalls = 0; retired = 0;
            fv = 0; dv = 0; ev = 0; wv = 0;
            fi = 0; di = 0; ei = 0; wi = 0; da = 0; ev_val = 0; wv_val = 0;
            for (int c = 0; c < 40; c++) begin
                bit nfv, ndv, nev, nwv;
                int nfi, ndi, nei, nwi, nda, nev_val, nwv_val, a, npc;
                @(negedge clk);
                if (hold_a) stalls++;
                a = (wv && p_rd[wi] == p_rs[fi] && p_rs[fi] != 0) ? wv_val : rf[p_rs[fi]];
                nwv = ev; nwi = ei;
                nwv_val = p_ld[ei] ? dmem(ev_val) : ev_val;
                nev = dv; nei = di; nev_val = da + p_imm[di];
                if (bub_a) begin ndv = 0; ndi = 0; nda = 0; end
                else begin ndv = fv; ndi = fi; nda = a; end
                npc = pc;
                if (ifh_a) begin nfv = fv; nfi = fi; end
                else if (pc < 7) begin nfv = 1; nfi = pc; npc = pc + 1; end
                else begin nfv = 0; nfi = 0; end
                if (hold_a) npc = pc;
                @(posedge clk); #1;
                if (wv) begin
                    retired++;
                    if (p_rd[wi] != 0) rf[p_rd[wi]] = wv_val;
                end
                wv = nwv; wi = nwi; wv_val = nwv_val;
                ev = nev; ei = nei; ev_val = nev_val;
                dv = ndv; di = ndi; da = nda;
                fv = nfv; fi = nfi; pc = npc;
                if (fv) drv(1, p_rs[fi], 1, 0, 0, p_rd[fi], 1, 0);
                else    drv(0, 0, 0, 0, 0, 0, 0, 0);
            end
            chk(retired == 7, "R9 retired count", retired, 7);
            chk(stalls == 7, "R9 stall cycles", stalls, 7);
            for (int r = 1; r < 8; r++)
                chk(rf[r] == sr[r], "R9 register value", rf[r], sr[r]);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule